// File: doc/BRIEF.md
# Capture/Compare Interval Timer

This block is a 16-bit up-counting timer with three capture/compare channels. It counts edges of one of four timing sources. Channel 0 holds the period limit: the counter runs from zero up to channel 0's value, returns to zero and raises an overflow flag. Channel 0 also flags its own compare match. It has no pin of its own.

Channels 1 and 2 each work in one of two modes. In compare mode a channel drives a pulse-width output in reset/set style. The output goes high when the counter returns to zero and low when the counter reaches the channel value, so the high time is the channel value in ticks out of a period of limit+1 ticks. In capture mode a channel copies the counter value on a chosen edge of a chosen input. That input can be either of two external signals, or a tied-low or tied-high level. Software can therefore force a capture by moving the select from low to high.

Each channel has its own event flag and a capture-overrun bit. Software sets up the timer through a small write-only register port. It observes the counter, the channel values, the flags and the outputs directly on ports.

Top module: `cct_top`

## Requirements
- R1: After reset the counter, all channel values, all flags, capture-overrun bits and pulse outputs are 0. The timer is stopped with source select 0.
- R2: Register 0 holds the run bit [0] and the source select [2:1] (0 external timer clock, 1 ACLK, 2 SMCLK, 3 auxiliary source). The counter advances once for each rising level change of the selected source only. Activity on the other three sources leaves the counter unchanged.
- R3: With run set, the counter steps 0,1,…,L, where L is the value in register 2 (channel 0). On the tick after L it returns to 0 and sets the overflow flag.
- R4: A channel in compare mode sets its event flag on the tick at which the counter takes that channel's value. For channel 0 this is the tick that reaches the limit L.
- R5: A compare-mode channel's pulse output rises on the tick that returns the counter to 0 and falls on the tick that reaches the channel value. A value of 0 keeps the output low, and a value above L keeps it high. pwm_o[0] belongs to channel 1 and pwm_o[1] to channel 2.
- R6: Channel n's control register (address 5+n) holds bit [0] capture mode and bits [2:1] edge mode (0 none, 1 rising, 2 falling, 3 both). In capture mode a matching edge of the selected input copies the counter value present at that clock edge into the channel value and sets the channel flag. A non-matching edge changes nothing.
- R7: Control bits [4:3] choose the capture input: 0 cap_a_i[n], 1 cap_b_i[n], 2 constant low, 3 constant high. The unselected input is ignored. Moving the select from 2 to 3 makes a rising edge, which performs a software capture.
- R8: A capture while the channel flag is still set sets that channel's capture-overrun bit. A capture with the flag clear does not.
- R9: Writing 1s to register 1 clears flags: bit 0 the overflow flag, bits [3:1] the channel 0..2 flags, bits [6:4] the channel 0..2 capture-overrun bits.
- R10: With run clear, source edges do not move the counter. Writing register 0 with bit [3] set forces the counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tclk_ext_i | input | 1 | External timer clock level (source 0) |
| aclk_i | input | 1 | ACLK level (source 1) |
| smclk_i | input | 1 | SMCLK level (source 2) |
| aux_clk_i | input | 1 | Auxiliary internal source level (source 3) |
| cap_a_i | input | 3 | Capture input A, one per channel |
| cap_b_i | input | 3 | Capture input B, one per channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| cnt_o | output | 16 | Counter value |
| ch_val_o | output | 48 | Channel values, channel n at bits [16n+15:16n] |
| pwm_o | output | 2 | Pulse outputs of channels 1 and 2 |
| ovf_flag_o | output | 1 | Counter overflow flag |
| ch_flag_o | output | 3 | Channel event flags |
| cap_ovf_o | output | 3 | Capture-overrun bits |

## Verification
The counter, overflow flag, compare flags and pulse outputs all change on the same clock edge that first samples the selected source high. A register write takes effect on the edge that samples the strobe. An external capture input change shows up in the channel value and flag one edge after it is driven. A software capture needs two edges after the write that selects the high level: one to register the select and one to see the edge. The bench drives every input on a falling edge and reads results on the next falling edge, or after the extra one for software captures. Each expected value comes from a counter model in the bench.

// File: rtl/cct_pkg.sv
`timescale 1ns/1ps
package cct_pkg;

  typedef enum logic [1:0] {
    CK_EXT   = 2'd0,
    CK_ACLK  = 2'd1,
    CK_SMCLK = 2'd2,
    CK_AUX   = 2'd3
  } clk_src_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } cap_edge_e;

  typedef enum logic [1:0] {
    IN_A    = 2'd0,
    IN_B    = 2'd1,
    IN_LOW  = 2'd2,
    IN_HIGH = 2'd3
  } cap_in_e;

  // packed: insel in [4:3], edge mode in [2:1], capture mode in [0]
  typedef struct packed {
    cap_in_e   insel;
    cap_edge_e edge_m;
    logic      cap_mode;
  } ch_ctrl_t;

  localparam int CH_CTRL_W = $bits(ch_ctrl_t);

endpackage

// File: rtl/cct_clk_sel.sv
`timescale 1ns/1ps
module cct_clk_sel
  import cct_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] src_i,
  input  clk_src_e   sel_i,
  output logic       tick_o
);

  logic src_sel;
  logic prev_q;
  logic prev_d;

  always_comb begin
    src_sel = src_i[sel_i];
    prev_d  = src_sel;
    tick_o  = src_sel & ~prev_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= prev_d;
  end

endmodule

// File: rtl/cct_counter.sv
`timescale 1ns/1ps
module cct_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o,
  output logic         adv_o,
  output logic         wrap_o
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    adv_o  = 1'b0;
    wrap_o = 1'b0;
    cnt_en = 1'b0;
    if (clr_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (run_i && tick_i) begin
      adv_o  = 1'b1;
      cnt_en = 1'b1;
      if (cnt_q == limit_i) begin
        cnt_d  = '0;
        wrap_o = 1'b1;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;

endmodule

// File: rtl/cct_channel.sv
`timescale 1ns/1ps
module cct_channel
  import cct_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  ch_ctrl_t     ctrl_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cnt_nxt_i,
  input  logic         adv_i,
  input  logic         wrap_i,
  input  logic         cap_a_i,
  input  logic         cap_b_i,
  input  logic         wr_val_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         flag_clr_i,
  input  logic         cov_clr_i,
  output logic [W-1:0] val_o,
  output logic         flag_o,
  output logic         cov_o,
  output logic         pwm_o
);

  logic [W-1:0] val_q, val_d;
  logic         flag_q, flag_d;
  logic         cov_q, cov_d;
  logic         pwm_q, pwm_d;
  logic         sig_q;
  logic         sig;
  logic         edge_hit;
  logic         cap_ev;
  logic         cmp_ev;

  always_comb begin
    unique case (ctrl_i.insel)
      IN_A:    sig = cap_a_i;
      IN_B:    sig = cap_b_i;
      IN_LOW:  sig = 1'b0;
      default: sig = 1'b1;
    endcase
  end

  always_comb begin
    edge_hit = (ctrl_i.edge_m[0] &  sig & ~sig_q) |
               (ctrl_i.edge_m[1] & ~sig &  sig_q);
    cap_ev   = ctrl_i.cap_mode & edge_hit;
    cmp_ev   = ~ctrl_i.cap_mode & adv_i & (cnt_nxt_i == val_q);
  end

  always_comb begin
    val_d  = val_q;
    flag_d = flag_q;
    cov_d  = cov_q;
    pwm_d  = pwm_q;

    if (cap_ev)        val_d = cnt_i;
    else if (wr_val_i) val_d = wr_data_i;

    if (cap_ev || cmp_ev) flag_d = 1'b1;
    else if (flag_clr_i)  flag_d = 1'b0;

    if (cap_ev && flag_q) cov_d = 1'b1;
    else if (cov_clr_i)   cov_d = 1'b0;

    if (!ctrl_i.cap_mode) begin
      if (cmp_ev)      pwm_d = 1'b0;
      else if (wrap_i) pwm_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      flag_q <= 1'b0;
      cov_q  <= 1'b0;
      pwm_q  <= 1'b0;
      sig_q  <= 1'b0;
    end else begin
      val_q  <= val_d;
      flag_q <= flag_d;
      cov_q  <= cov_d;
      pwm_q  <= pwm_d;
      sig_q  <= sig;
    end
  end

  assign val_o  = val_q;
  assign flag_o = flag_q;
  assign cov_o  = cov_q;
  assign pwm_o  = pwm_q;

endmodule

// File: rtl/cct_top.sv
`timescale 1ns/1ps
module cct_top
  import cct_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_CH   = 3,
  parameter int ADDR_W = $clog2(2 + 2 * N_CH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tclk_ext_i,
  input  logic                  aclk_i,
  input  logic                  smclk_i,
  input  logic                  aux_clk_i,
  input  logic [N_CH-1:0]       cap_a_i,
  input  logic [N_CH-1:0]       cap_b_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [CNT_W-1:0]      wr_data_i,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [N_CH*CNT_W-1:0] ch_val_o,
  output logic [N_CH-2:0]       pwm_o,
  output logic                  ovf_flag_o,
  output logic [N_CH-1:0]       ch_flag_o,
  output logic [N_CH-1:0]       cap_ovf_o
);

  localparam int A_CTRL  = 0;
  localparam int A_FCLR  = 1;
  localparam int A_VAL0  = 2;
  localparam int A_CCTL0 = A_VAL0 + N_CH;
  localparam int B_RUN   = 0;
  localparam int B_SEL   = 1;
  localparam int B_CLR   = 3;
  localparam int B_FCH   = 1;
  localparam int B_FCOV  = 1 + N_CH;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // control register
  logic     run_q, run_d;
  clk_src_e sel_q, sel_d;
  logic     ctrl_we;
  logic     fclr_we;
  logic     cnt_clr;

  always_comb begin
    ctrl_we = wr_en_i && (wr_addr_i == ADDR_W'(A_CTRL));
    fclr_we = wr_en_i && (wr_addr_i == ADDR_W'(A_FCLR));
    cnt_clr = ctrl_we && wr_data_i[B_CLR];
    run_d   = ctrl_we ? wr_data_i[B_RUN] : run_q;
    sel_d   = ctrl_we ? clk_src_e'(wr_data_i[B_SEL +: 2]) : sel_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      sel_q <= CK_EXT;
    end else begin
      run_q <= run_d;
      sel_q <= sel_d;
    end
  end

  // timing source and counter
  logic             tick;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             adv, wrap;
  logic [CNT_W-1:0] ch_val [N_CH];

  cct_clk_sel u_clk_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .src_i  ({aux_clk_i, smclk_i, aclk_i, tclk_ext_i}),
    .sel_i  (sel_q),
    .tick_o (tick)
  );

  cct_counter #(.W(CNT_W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .run_i     (run_q),
    .clr_i     (cnt_clr),
    .limit_i   (ch_val[0]),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt),
    .adv_o     (adv),
    .wrap_o    (wrap)
  );

  // overflow flag
  logic ovf_q, ovf_d;

  always_comb begin
    ovf_d = ovf_q;
    if (wrap)                         ovf_d = 1'b1;
    else if (fclr_we && wr_data_i[0]) ovf_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  // channels
  logic [N_CH-1:0] pwm_all;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    ch_ctrl_t cctl_q;
    ch_ctrl_t cctl_d;
    logic     cctl_we;
    logic     val_we;

    always_comb begin
      cctl_we = wr_en_i && (wr_addr_i == ADDR_W'(A_CCTL0 + i));
      val_we  = wr_en_i && (wr_addr_i == ADDR_W'(A_VAL0 + i));
      cctl_d  = cctl_we ? ch_ctrl_t'(wr_data_i[CH_CTRL_W-1:0]) : cctl_q;
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) cctl_q <= '0;
      else        cctl_q <= cctl_d;
    end

    cct_channel #(.W(CNT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_n),
      .ctrl_i     (cctl_q),
      .cnt_i      (cnt),
      .cnt_nxt_i  (cnt_nxt),
      .adv_i      (adv),
      .wrap_i     (wrap),
      .cap_a_i    (cap_a_i[i]),
      .cap_b_i    (cap_b_i[i]),
      .wr_val_i   (val_we),
      .wr_data_i  (wr_data_i),
      .flag_clr_i (fclr_we && wr_data_i[B_FCH + i]),
      .cov_clr_i  (fclr_we && wr_data_i[B_FCOV + i]),
      .val_o      (ch_val[i]),
      .flag_o     (ch_flag_o[i]),
      .cov_o      (cap_ovf_o[i]),
      .pwm_o      (pwm_all[i])
    );

    assign ch_val_o[i*CNT_W +: CNT_W] = ch_val[i];
  end

  assign pwm_o      = pwm_all[N_CH-1:1];
  assign cnt_o      = cnt;
  assign ovf_flag_o = ovf_q;

endmodule

// File: rtl/cct_chk.sv
`timescale 1ns/1ps
module cct_chk #(
  parameter int W    = 16,
  parameter int N_CH = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [W-1:0]      cnt_i,
  input logic [N_CH*W-1:0] val_i,
  input logic [N_CH-1:0]   pwm_i,
  input logic              ovf_i,
  input logic [N_CH-1:0]   flag_i,
  input logic [N_CH-1:0]   cov_i
);

  // R3: the overflow flag only comes up on a return from the limit to zero
  assert_ovf_on_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_i) |-> (cnt_i == '0) && ($past(cnt_i) == $past(val_i[W-1:0])));

  // R3, R10: the counter moves by a single step or goes to zero
  assert_count_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != $past(cnt_i)) |-> ((cnt_i == '0) || (cnt_i == W'($past(cnt_i) + 1'b1))));

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    // R5: output rises only as the counter lands on zero
    assert_pwm_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pwm_i[i]) |-> (cnt_i == '0));

    // R5: output falls only as the counter lands on the channel value
    assert_pwm_reset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pwm_i[i]) |-> (cnt_i == $past(val_i[i*W +: W])));

    // R8: overrun comes up only while the channel flag was already set
    assert_cov_needs_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cov_i[i]) |-> $past(flag_i[i]));
  end

endmodule

bind cct_top cct_chk #(.W(CNT_W), .N_CH(N_CH)) u_cct_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cnt_i  (cnt_o),
  .val_i  (ch_val_o),
  .pwm_i  (pwm_all),
  .ovf_i  (ovf_flag_o),
  .flag_i (ch_flag_o),
  .cov_i  (cap_ovf_o)
);

// File: tb/cct_top_tb.sv
`timescale 1ns/1ps
module cct_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src = 4'h0;
  logic [2:0]  cap_a = 3'h0;
  logic [2:0]  cap_b = 3'h0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'h0;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] cnt;
  logic [47:0] ch_val;
  logic [1:0]  pwm;
  logic        ovf;
  logic [2:0]  ch_flag;
  logic [2:0]  cov;

  int n_chk = 0;
  int n_err = 0;
  int m = 0;
  localparam int LIM = 4;

  always #4 clk = ~clk;

  cct_top dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tclk_ext_i (src[0]),
    .aclk_i     (src[1]),
    .smclk_i    (src[2]),
    .aux_clk_i  (src[3]),
    .cap_a_i    (cap_a),
    .cap_b_i    (cap_b),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .cnt_o      (cnt),
    .ch_val_o   (ch_val),
    .pwm_o      (pwm),
    .ovf_flag_o (ovf),
    .ch_flag_o  (ch_flag),
    .cap_ovf_o  (cov)
  );

  function automatic logic [15:0] val(input int n);
    return ch_val[n*16 +: 16];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(input int s);
    @(negedge clk);
    src[s] = 1'b1;
    @(negedge clk);
    src[s] = 1'b0;
  endtask

  task automatic adv(input int s);
    tick(s);
    m = (m == LIM) ? 0 : m + 1;
  endtask

  task automatic t_reset();
    chk("R1 counter", cnt, 0);
    chk("R1 values", ch_val, 0);
    chk("R1 flags", {ovf, ch_flag, cov}, 0);
    chk("R1 pwm", pwm, 0);
    tick(0);
    chk("R1 stopped at reset", cnt, 0);
  endtask

  task automatic t_upmode();
    logic p1, p2;
    p1 = 1'b0; p2 = 1'b0;
    wr(3'd2, 16'(LIM));
    wr(3'd3, 16'd2);
    wr(3'd4, 16'd7);
    wr(3'd0, 16'h0001);
    for (int i = 0; i < 12; i++) begin
      adv(0);
      chk("R3 count", cnt, m);
      chk("R4 ch0 compare flag", ch_flag[0], (m == LIM));
      if (m == LIM) begin
        wr(3'd1, 16'h0002);
        chk("R9 ch0 flag clear", ch_flag[0], 0);
      end
      chk("R3 overflow flag", ovf, (m == 0));
      if (m == 0) begin
        wr(3'd1, 16'h0001);
        chk("R9 overflow clear", ovf, 0);
      end
      if (m == 2) p1 = 1'b0; else if (m == 0) p1 = 1'b1;
      if (m == 0) p2 = 1'b1;
      chk("R5 pwm duty", pwm, {p2, p1});
    end
  endtask

  task automatic t_clksel();
    wr(3'd0, 16'h0003);
    tick(0);
    chk("R2 unselected ext ignored", cnt, m);
    adv(1);
    chk("R2 aclk counts", cnt, m);
    wr(3'd0, 16'h0005);
    tick(1);
    chk("R2 unselected aclk ignored", cnt, m);
    adv(2);
    chk("R2 smclk counts", cnt, m);
    wr(3'd0, 16'h0007);
    adv(3);
    chk("R2 aux counts", cnt, m);
    if (m == 0) adv(3);
    wr(3'd0, 16'h0006);
    tick(3);
    chk("R10 run clear holds", cnt, m);
    wr(3'd0, 16'h000E);
    m = 0;
    chk("R10 clear bit zeroes", cnt, 0);
  endtask

  task automatic t_capture();
    wr(3'd0, 16'h0007);
    wr(3'd6, 16'h0003);
    wr(3'd1, 16'h007F);
    adv(3); adv(3); adv(3);
    @(negedge clk) cap_a[1] = 1'b1;
    @(negedge clk);
    chk("R6 rising capture value", val(1), 3);
    chk("R6 capture flag", ch_flag[1], 1);
    chk("R8 no overrun first", cov[1], 0);
    adv(3);
    @(negedge clk) cap_a[1] = 1'b0;
    @(negedge clk);
    chk("R6 falling ignored in rising mode", val(1), 3);
    wr(3'd6, 16'h0007);
    adv(3); adv(3);
    @(negedge clk) cap_a[1] = 1'b1;
    @(negedge clk);
    chk("R6 both mode rising", val(1), m);
    chk("R8 overrun set", cov[1], 1);
    wr(3'd1, 16'h0024);
    chk("R9 flag and overrun clear", {ch_flag[1], cov[1]}, 0);
    adv(3);
    @(negedge clk) cap_a[1] = 1'b0;
    @(negedge clk);
    chk("R6 both mode falling", val(1), m);
    chk("R8 no overrun after clear", {ch_flag[1], cov[1]}, 2'b10);
    wr(3'd6, 16'h0001);
    adv(3);
    @(negedge clk) cap_a[1] = 1'b1;
    @(negedge clk);
    chk("R6 edge none ignores", val(1), (m == 0) ? LIM : m - 1);
  endtask

  task automatic t_select();
    wr(3'd7, 16'd11);
    @(negedge clk) cap_a[2] = 1'b1;
    @(negedge clk);
    chk("R7 unselected A ignored", val(2), 7);
    @(negedge clk) cap_b[2] = 1'b1;
    @(negedge clk);
    chk("R7 input B capture", val(2), m);
    adv(3);
    wr(3'd7, 16'd19);
    wr(3'd7, 16'd27);
    @(negedge clk);
    chk("R7 software capture", val(2), m);
  endtask

  task automatic t_pwm_edges();
    int seen;
    seen = 0;
    wr(3'd6, 16'd0);
    wr(3'd3, 16'd0);
    wr(3'd7, 16'd0);
    wr(3'd4, 16'd9);
    for (int i = 0; i < 7; i++) begin
      adv(3);
      if (m == 0) seen = 1;
      if (seen != 0) chk("R5 zero value low, large value high", pwm, 2'b10);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_upmode();
    t_clksel();
    t_capture();
    t_select();
    t_pwm_edges();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule